// File: doc/BRIEF.md
# Keyed 64-bit Watchdog Timer

A 64-bit up-counter on a small 32-bit register bus. Software loads a 64-bit period and starts the counter in continuous mode. It then arms the watchdog by writing two 16-bit keys in a fixed order. Once the watchdog is armed, software must repeat the key pair before the counter reaches the period. If it does not, the block raises a sticky timeout flag and a one-clock reset request.

The key pair is a two-step handshake. The first key moves the watchdog out of its current state and into an intermediate one. The second key completes the step. When the watchdog is idle, the handshake arms it. When it is active, the handshake reloads the counter. A key that does not fit the sequence drops the watchdog back to the state it held before the sequence began, and the counter is not reloaded. From the first arming key onward, every timer register is locked against writes. Only the key field of the watchdog control register still has an effect.

Software reads the counter halves and the flag to learn how much time remains and whether a timeout has happened. Reads have no side effects, and every write completes in a single clock.

Top module: `wdk_timer_top`

## Requirements
- R1: After a synchronous reset, every register reads zero, `rst_req` is low and the watchdog is idle, so all registers accept writes.
- R2: The registers are mapped as follows: low and high counter halves at 0x10 and 0x14, low and high period halves at 0x18 and 0x1C, the run control at 0x20 (run mode in bits 7:6), the global control at 0x24 (bits 3:0) and the watchdog control at 0x28. In the watchdog control register, bit 14 is the enable, bit 15 is the timeout flag and bits 31:16 take the key. The key bits read as zero, and any unmapped offset reads zero.
- R3: The counter adds one on every clock when all three of these hold: global control bits 1:0 are 11, global control bits 3:2 are 10 (64-bit watchdog mode), and the run mode is 1 or 2. The carry passes from the low half into the high half. In run mode 2 (continuous), the clock after the count equals the period loads zero. In run mode 0, the counter holds its value.
- R4: In run mode 1 (one-shot), the counter stops at the period, and the run mode field reads back as 0.
- R5: While global control bit 0 is clear, the low counter half is held at zero and writes to it are discarded. Bit 1 does the same for the high half.
- R6: In idle, a write of key 0xA5C6 with bit 14 set enters pre-active. From pre-active, a write of key 0xDA7E with bit 14 set enters active.
- R7: In idle, any other watchdog control write leaves the watchdog idle. This includes 0xDA7E and a 0xA5C6 written without bit 14. In pre-active, any write other than 0xDA7E with bit 14 set returns the watchdog to idle.
- R8: From pre-active onward, writes to offsets 0x10 through 0x24 and to the enable bit have no effect, and the counter keeps running.
- R9: In active, a write of 0xA5C6 enters the service state. A following write of 0xDA7E reloads the counter, so it reads zero before the next clock, and the watchdog returns to active.
- R10: In active or service, a key write that does not fit the sequence returns the watchdog to active and leaves the counter unreloaded.
- R11: When the watchdog is armed and the count equals the period, the timeout flag (bit 15) sets and `rst_req` is high for exactly one clock on the next edge. With period P, this happens P+1 clocks after the reload.
- R12: The timeout flag stays set until reset. Later period matches raise no further `rst_req` pulse, and writes to bit 15 do not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | One-clock reset request on timeout |

## Verification
The hardest state to reach from the ports is a timeout that follows a long run of correct and incorrect key writes. The bench cannot see the watchdog state directly, so it infers each state from its side effects. A write to the period register that does or does not stick shows whether the registers are locked. A counter that does or does not read zero right after a key pair shows whether a reload happened. The stimulus keeps a short period running while it interleaves misordered keys, so every rejected sequence has a visible effect on the counter before the deadline expires. Finally, it stops servicing and measures the exact clock of the single reset pulse.

// File: rtl/wdk_pkg.sv
// Package: shared constants and types for the keyed watchdog timer.
// Assumes a byte-addressed register bus with a 4-byte register stride.
package wdk_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_PRE  = 2'd1,
        WD_ACT  = 2'd2,
        WD_SVC  = 2'd3
    } wd_state_e;

    // register indices, ordered by offset
    localparam int REG_CNT_LO = 0;
    localparam int REG_CNT_HI = 1;
    localparam int REG_PRD_LO = 2;
    localparam int REG_PRD_HI = 3;
    localparam int REG_TCTL   = 4;
    localparam int REG_GCTL   = 5;
    localparam int REG_WCTL   = 6;
    localparam int N_REGS     = 7;
    localparam int REG_BASE   = 16;
    localparam int REG_STRIDE = 4;

    localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
    localparam logic [15:0] KEY_SECOND = 16'hDA7E;
    localparam int KEY_LSB       = 16;
    localparam int KEY_W         = 16;
    localparam int WCTL_EN_BIT   = 14;
    localparam int WCTL_FLAG_BIT = 15;

    localparam int TCTL_MODE_LSB = 6;
    localparam logic [1:0] RUN_OFF  = 2'd0;
    localparam logic [1:0] RUN_ONCE = 2'd1;
    localparam logic [1:0] RUN_LOOP = 2'd2;
    localparam int GCTL_W = 4;
    localparam logic [1:0] GMODE_WDOG64 = 2'd2;

endpackage

// File: rtl/wdk_bus_decode.sv
// Module: address decode and read multiplexer for the register bank.
// Produces one write strobe per register and selects read data by offset.
// Assumes at most one register matches any address.
module wdk_bus_decode
    import wdk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                           we_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [N_REGS-1:0][DATA_W-1:0]  rd_vals_i,
    output logic [N_REGS-1:0]              wr_sel_o,
    output logic [DATA_W-1:0]              rdata_o
);

    logic [N_REGS-1:0] match;

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_BASE + i * REG_STRIDE);
        assign match[i]    = (addr_i == OFS);
        assign wr_sel_o[i] = we_i && match[i];
    end

    // Purpose: return the matching register, zero for an unmapped offset.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (match[i]) rdata_o = rd_vals_i[i];
        end
    end

endmodule

// File: rtl/wdk_key_fsm.sv
// Module: key handshake state machine (idle, pre-active, active, service).
// Assumes key_we_i is a single-clock strobe for a watchdog control write.
// A second key accepted from the service state raises reload_o in the same cycle.
module wdk_key_fsm
    import wdk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             en_bit_i,
    output wd_state_e        state_o,
    output logic             locked_o,
    output logic             armed_o,
    output logic             reload_o
);

    wd_state_e state_q, state_d;

    // Purpose: next state and reload decision from the key written this cycle.
    always_comb begin
        state_d  = state_q;
        reload_o = 1'b0;
        if (key_we_i) begin
            unique case (state_q)
                WD_IDLE: if (key_i == KEY_FIRST && en_bit_i) state_d = WD_PRE;
                WD_PRE:  state_d = (key_i == KEY_SECOND && en_bit_i) ? WD_ACT : WD_IDLE;
                WD_ACT:  if (key_i == KEY_FIRST) state_d = WD_SVC;
                WD_SVC: begin
                    state_d  = WD_ACT;
                    reload_o = (key_i == KEY_SECOND);
                end
                default: state_d = WD_IDLE;
            endcase
        end
    end

    // Purpose: hold the handshake state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    assign state_o  = state_q;
    assign locked_o = (state_q != WD_IDLE);
    assign armed_o  = (state_q == WD_ACT) || (state_q == WD_SVC);

endmodule

// File: rtl/wdk_counter64.sv
// Module: wide up-counter built from equal halves, each writable and each held
// at zero by its own reset-release bit. A half write overrides the count step
// for that half only. Assumes the write strobes are already gated by the lock.
module wdk_counter64 #(
    parameter  int HALF_W = 32,
    parameter  int N_HALF = 2,
    localparam int CNT_W  = HALF_W * N_HALF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wrap_i,
    input  logic              reload_i,
    input  logic [N_HALF-1:0] wr_half_i,
    input  logic [N_HALF-1:0] hold_half_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  prd_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              hit_o
);

    logic [HALF_W-1:0] half_q [N_HALF];
    logic [CNT_W-1:0]  step;

    for (genvar h = 0; h < N_HALF; h++) begin : g_join
        assign cnt_o[h*HALF_W +: HALF_W] = half_q[h];
    end

    assign hit_o = run_i && (cnt_o == prd_i);

    // Purpose: the count the counter would take with no bus write this cycle.
    always_comb begin
        step = cnt_o;
        if (run_i) begin
            if (cnt_o == prd_i) step = wrap_i ? '0 : cnt_o;
            else                step = cnt_o + 1'b1;
        end
        if (reload_i) step = '0;
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        // Purpose: update one half: held, written, or stepped.
        always_ff @(posedge clk) begin
            if (!rst_n)              half_q[h] <= '0;
            else if (hold_half_i[h]) half_q[h] <= '0;
            else if (wr_half_i[h])   half_q[h] <= wdata_i;
            else                     half_q[h] <= step[h*HALF_W +: HALF_W];
        end
    end

endmodule

// File: rtl/wdk_cfg_regs.sv
// Module: period halves, run control, global control and the enable bit.
// Writes are dropped while locked. A finished one-shot run clears the run mode.
// Assumes wr_sel_i comes straight from the decoder.
module wdk_cfg_regs
    import wdk_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int N_HALF = 2,
    localparam int PRD_W  = DATA_W * N_HALF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REGS-1:0] wr_sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              locked_i,
    input  logic              oneshot_done_i,
    output logic [PRD_W-1:0]  prd_o,
    output logic [1:0]        mode_o,
    output logic [GCTL_W-1:0] gctl_o,
    output logic              en_o
);

    logic [DATA_W-1:0] prd_q [N_HALF];
    logic              open_wr;

    assign open_wr = !locked_i;

    for (genvar h = 0; h < N_HALF; h++) begin : g_prd
        localparam int SEL = REG_PRD_LO + h;
        // Purpose: store one period half.
        always_ff @(posedge clk) begin
            if (!rst_n)                      prd_q[h] <= '0;
            else if (wr_sel_i[SEL] && open_wr) prd_q[h] <= wdata_i;
        end
        assign prd_o[h*DATA_W +: DATA_W] = prd_q[h];
    end

    // Purpose: run mode; a write wins over the one-shot self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mode_o <= RUN_OFF;
        else if (wr_sel_i[REG_TCTL] && open_wr) mode_o <= wdata_i[TCTL_MODE_LSB +: 2];
        else if (oneshot_done_i)             mode_o <= RUN_OFF;
    end

    // Purpose: half reset releases and the timer mode field.
    always_ff @(posedge clk) begin
        if (!rst_n)                          gctl_o <= '0;
        else if (wr_sel_i[REG_GCTL] && open_wr) gctl_o <= wdata_i[GCTL_W-1:0];
    end

    // Purpose: watchdog enable bit, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_o <= 1'b0;
        else if (wr_sel_i[REG_WCTL] && open_wr) en_o <= wdata_i[WCTL_EN_BIT];
    end

endmodule

// File: rtl/wdk_timer_top.sv
// Module: keyed 64-bit watchdog timer top. Joins the decoder, the
// configuration registers, the counter and the key state machine. Raises a
// sticky flag and a one-clock reset request on the first armed timeout.
// Assumes a single clock domain and a synchronous active-low reset.
module wdk_timer_top
    import wdk_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int DATA_W = 32,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    logic [N_REGS-1:0]             wr_sel;
    logic [N_REGS-1:0][DATA_W-1:0] rd_vals;
    logic [CNT_W-1:0]              cnt_val, prd_val;
    logic [1:0]                    mode;
    logic [GCTL_W-1:0]             gctl;
    logic                          en_q, flag_q;
    logic                          locked, armed, reload, hit, run;
    wd_state_e                     wd_state;

    wdk_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .rd_vals_i (rd_vals),
        .wr_sel_o  (wr_sel),
        .rdata_o   (bus_rdata)
    );

    wdk_key_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we_i (wr_sel[REG_WCTL]),
        .key_i    (bus_wdata[KEY_LSB +: KEY_W]),
        .en_bit_i (bus_wdata[WCTL_EN_BIT]),
        .state_o  (wd_state),
        .locked_o (locked),
        .armed_o  (armed),
        .reload_o (reload)
    );

    wdk_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_sel_i       (wr_sel),
        .wdata_i        (bus_wdata),
        .locked_i       (locked),
        .oneshot_done_i (hit && (mode == RUN_ONCE)),
        .prd_o          (prd_val),
        .mode_o         (mode),
        .gctl_o         (gctl),
        .en_o           (en_q)
    );

    assign run = (gctl[1:0] == 2'b11) && (gctl[3:2] == GMODE_WDOG64)
              && ((mode == RUN_ONCE) || (mode == RUN_LOOP));

    wdk_counter64 #(.HALF_W(DATA_W), .N_HALF(2)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .wrap_i      (mode == RUN_LOOP),
        .reload_i    (reload),
        .wr_half_i   ({wr_sel[REG_CNT_HI], wr_sel[REG_CNT_LO]} & {2{!locked}}),
        .hold_half_i (~gctl[1:0]),
        .wdata_i     (bus_wdata),
        .prd_i       (prd_val),
        .cnt_o       (cnt_val),
        .hit_o       (hit)
    );

    // Purpose: sticky timeout flag and a request on the first armed match only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            rst_req <= 1'b0;
        end else if (hit && armed) begin
            flag_q  <= 1'b1;
            rst_req <= !flag_q;
        end else begin
            rst_req <= 1'b0;
        end
    end

    // Purpose: assemble read values in register index order.
    always_comb begin
        rd_vals                 = '0;
        rd_vals[REG_CNT_LO]     = cnt_val[DATA_W-1:0];
        rd_vals[REG_CNT_HI]     = cnt_val[CNT_W-1:DATA_W];
        rd_vals[REG_PRD_LO]     = prd_val[DATA_W-1:0];
        rd_vals[REG_PRD_HI]     = prd_val[CNT_W-1:DATA_W];
        rd_vals[REG_TCTL][TCTL_MODE_LSB +: 2] = mode;
        rd_vals[REG_GCTL][GCTL_W-1:0]         = gctl;
        rd_vals[REG_WCTL][WCTL_EN_BIT]        = en_q;
        rd_vals[REG_WCTL][WCTL_FLAG_BIT]      = flag_q;
    end

endmodule

// File: rtl/wdk_timer_chk.sv
// Module: property checker for the keyed watchdog timer, bound to the top.
// Assumes the same clock and synchronous reset as the design.
module wdk_timer_chk
    import wdk_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int DATA_W = 32,
    localparam int CNT_W  = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [KEY_W-1:0]  key,
    input logic              en_bit,
    input logic              rst_req,
    input wd_state_e         state,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  prd,
    input logic [GCTL_W-1:0] gctl,
    input logic              flag
);

    localparam logic [ADDR_W-1:0] WCTL_OFS = ADDR_W'(REG_BASE + REG_WCTL * REG_STRIDE);

    logic key_wr;
    assign key_wr = bus_we && (bus_addr == WCTL_OFS);

    assert_arm_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_PRE && key_wr && key == KEY_SECOND && en_bit) |=> (state == WD_ACT));

    assert_pre_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_PRE && key_wr && !(key == KEY_SECOND && en_bit)) |=> (state == WD_IDLE));

    assert_period_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WD_IDLE) |=> $stable(prd));

    assert_gctl_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WD_IDLE) |=> $stable(gctl));

    assert_service_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_SVC && key_wr && key == KEY_SECOND) |=> (cnt == '0));

    assert_stays_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_ACT || state == WD_SVC) |=> (state == WD_ACT || state == WD_SVC));

    assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_req_has_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> flag);

    assert_req_when_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(state) == WD_ACT || $past(state) == WD_SVC));

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);

endmodule

bind wdk_timer_top wdk_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .key      (bus_wdata[31:16]),
    .en_bit   (bus_wdata[14]),
    .rst_req  (rst_req),
    .state    (wd_state),
    .cnt      (cnt_val),
    .prd      (prd_val),
    .gctl     (gctl),
    .flag     (flag_q)
);

// File: tb/wdk_timer_top_tb_top.sv
// Bench: a behavioural reference model, compared on every clock, plus
// directed checks with hand-derived expected values.
module wdk_timer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [31:0] K0_EN = 32'hA5C6_4000;
    localparam logic [31:0] K1_EN = 32'hDA7E_4000;
    localparam logic [31:0] K0    = 32'hA5C6_0000;
    localparam logic [31:0] K1    = 32'hDA7E_0000;

    always #10 clk = ~clk;   // 50 MHz

    wdk_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    // ---------------- reference model ----------------
    longint unsigned m_cnt, m_prd;
    int  m_mode, m_gctl, m_state;   // state: 0 idle, 1 pre, 2 active, 3 service
    bit  m_en, m_flag, m_req;

    always @(posedge clk) begin : model
        longint unsigned nc;
        bit run, hit, wk, k0, k1, en;
        int nmode, ostate;
        if (!rst_n) begin
            m_cnt = 0; m_prd = 0; m_mode = 0; m_gctl = 0; m_state = 0;
            m_en = 0; m_flag = 0; m_req = 0;
        end else begin
            ostate = m_state;
            run = ((m_gctl & 3) == 3) && (((m_gctl >> 2) & 3) == 2) && (m_mode == 1 || m_mode == 2);
            hit = run && (m_cnt == m_prd);
            nc = m_cnt;
            if (run) nc = hit ? ((m_mode == 2) ? 64'd0 : m_cnt) : m_cnt + 1;
            nmode = (hit && m_mode == 1) ? 0 : m_mode;
            m_req = 0;
            if (hit && ostate >= 2) begin
                m_req = !m_flag;
                m_flag = 1;
            end
            wk = bus_we && bus_addr == 8'h28;
            k0 = bus_wdata[31:16] == 16'hA5C6;
            k1 = bus_wdata[31:16] == 16'hDA7E;
            en = bus_wdata[14];
            if (wk) begin
                case (ostate)
                    0: if (k0 && en) m_state = 1;
                    1: m_state = (k1 && en) ? 2 : 0;
                    2: if (k0) m_state = 3;
                    default: begin
                        m_state = 2;
                        if (k1) nc = 0;
                    end
                endcase
                if (ostate == 0) m_en = en;
            end
            if (bus_we && ostate == 0) begin
                case (bus_addr)
                    8'h10: nc[31:0]  = bus_wdata;
                    8'h14: nc[63:32] = bus_wdata;
                    8'h18: m_prd[31:0]  = bus_wdata;
                    8'h1C: m_prd[63:32] = bus_wdata;
                    8'h20: nmode = int'(bus_wdata[7:6]);
                    8'h24: m_gctl = int'(bus_wdata[3:0]);
                    default: ;
                endcase
            end
            if ((m_gctl_prev() & 1) == 0) nc[31:0]  = 0;
            if ((m_gctl_prev() & 2) == 0) nc[63:32] = 0;
            m_cnt = nc;
            m_mode = nmode;
        end
    end

    // global control before this edge's write (captured each edge)
    int gctl_old = 0;
    always @(negedge clk) gctl_old = m_gctl;
    function automatic int m_gctl_prev();
        return gctl_old;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h10: return m_cnt[31:0];
            8'h14: return m_cnt[63:32];
            8'h18: return m_prd[31:0];
            8'h1C: return m_prd[63:32];
            8'h20: return 32'(m_mode) << 6;
            8'h24: return 32'(m_gctl);
            8'h28: return {16'h0, m_flag, m_en, 14'h0};
            default: return 32'h0;
        endcase
    endfunction

    // per-clock comparison against the model (R2, R3, R11)
    always @(negedge clk) begin
        #5;
        n_tests++;
        if (rst_req !== m_req || bus_rdata !== m_read(bus_addr)) begin
            n_fail++;
            $display("FAIL R3/R11 model: addr=%h rdata=%h exp=%h rst_req=%b exp=%b",
                     bus_addr, bus_rdata, m_read(bus_addr), rst_req, m_req);
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    // watchdog for a hung run
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b, c, mx;
        bit saw0;
        int waited, pulses;

        @(negedge clk);
        do_reset();

        // R1: reset state
        for (int i = 0; i < 7; i++) begin
            rd(8'(8'h10 + 4 * i), v);
            check("R1 reset value", v, 32'h0);
        end
        check("R1 rst_req low", 32'(rst_req), 32'h0);

        // R2: register map and readback masks
        wr(8'h24, 32'h0000_0003);
        wr(8'h10, 32'h1234_5678); rd(8'h10, v); check("R2 cnt_lo", v, 32'h1234_5678);
        wr(8'h14, 32'h9ABC_DEF0); rd(8'h14, v); check("R2 cnt_hi", v, 32'h9ABC_DEF0);
        wr(8'h18, 32'h0F0F_0F0F); rd(8'h18, v); check("R2 prd_lo", v, 32'h0F0F_0F0F);
        wr(8'h1C, 32'hA5A5_A5A5); rd(8'h1C, v); check("R2 prd_hi", v, 32'hA5A5_A5A5);
        wr(8'h20, 32'hFFFF_FF40); rd(8'h20, v); check("R2 tctl mask", v, 32'h0000_0040);
        wr(8'h24, 32'hFFFF_FFF3); rd(8'h24, v); check("R2 gctl mask", v, 32'h0000_0003);
        wr(8'h28, 32'hFFFF_C000); rd(8'h28, v); check("R2 wctl en only, R12 flag not writable", v, 32'h0000_4000);
        rd(8'h2C, v); check("R2 unmapped", v, 32'h0);

        // R7: out-of-order and enable-less keys do not lock; R8 lock in pre-active
        wr(8'h28, K1_EN); wr(8'h18, 32'h11); rd(8'h18, v); check("R7 second key first", v, 32'h11);
        wr(8'h28, K0);    wr(8'h18, 32'h12); rd(8'h18, v); check("R7 first key no enable", v, 32'h12);
        wr(8'h28, K0_EN); wr(8'h18, 32'h22); rd(8'h18, v); check("R6 R8 pre-active locks period", v, 32'h12);
        wr(8'h28, K0_EN); wr(8'h18, 32'h33); rd(8'h18, v); check("R7 repeated first key unlocks", v, 32'h33);
        wr(8'h28, K0_EN); wr(8'h28, K1);     wr(8'h18, 32'h44); rd(8'h18, v);
        check("R7 second key without enable unlocks", v, 32'h44);

        // R3: continuous counting rate
        wr(8'h24, 32'hB); wr(8'h18, 32'd1000); wr(8'h1C, 0); wr(8'h10, 0); wr(8'h14, 0);
        wr(8'h20, 32'h80);
        rd(8'h10, a); tick(5); rd(8'h10, b);
        check("R3 one per clock", b - a, 32'd6);

        // R4: one-shot stops at period and clears mode
        wr(8'h20, 0); wr(8'h10, 0); wr(8'h18, 32'd5); wr(8'h20, 32'h40);
        tick(20);
        rd(8'h10, v); check("R4 one-shot stop", v, 32'd5);
        rd(8'h20, v); check("R4 mode cleared", v, 32'h0);

        // R3: wrap after period in continuous mode
        wr(8'h10, 0); wr(8'h18, 32'd3); wr(8'h20, 32'h80);
        mx = 0; saw0 = 0;
        for (int i = 0; i < 12; i++) begin
            rd(8'h10, v);
            if (v > mx) mx = v;
            if (v == 0) saw0 = 1;
        end
        check("R3 wrap max", mx, 32'd3);
        check("R3 wrap reaches zero", 32'(saw0), 32'd1);

        // R3: carry into the high half
        wr(8'h20, 0); wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'd1);
        wr(8'h10, 32'hFFFF_FFFD); wr(8'h14, 0); wr(8'h20, 32'h80);
        tick(6);
        rd(8'h14, v); check("R3 carry", v, 32'd1);

        // R5: half reset hold
        wr(8'h24, 32'h9); tick(1);
        rd(8'h14, v); check("R5 high half held", v, 32'h0);
        wr(8'h14, 32'd5); rd(8'h14, v); check("R5 high write discarded", v, 32'h0);
        wr(8'h24, 32'hA); tick(1);
        rd(8'h10, v); check("R5 low half held", v, 32'h0);

        // R3: run mode 0 holds
        wr(8'h24, 32'hB); wr(8'h20, 0); wr(8'h10, 32'd7);
        rd(8'h10, a); tick(3); rd(8'h10, b);
        check("R3 mode 0 holds", b, 32'd7);

        // R6/R8: arm, then every locked write is dropped
        wr(8'h18, 32'd60); wr(8'h1C, 0); wr(8'h10, 0); wr(8'h14, 0);
        wr(8'h20, 32'h80);
        wr(8'h28, K0_EN); wr(8'h28, K1_EN);
        wr(8'h10, 32'hDEAD); wr(8'h18, 32'h7); wr(8'h20, 0); wr(8'h24, 0); wr(8'h28, 32'h0);
        rd(8'h18, v); check("R8 period locked", v, 32'd60);
        rd(8'h20, v); check("R8 run control locked", v, 32'h80);
        rd(8'h24, v); check("R8 global control locked", v, 32'hB);
        rd(8'h28, v); check("R8 enable bit locked", v, 32'h4000);
        rd(8'h10, v); check("R8 counter still running", 32'(v < 32'd60 && v != 0), 32'd1);

        // R9: service pair reloads
        wr(8'h28, K0); wr(8'h28, K1); rd(8'h10, v);
        check("R9 reload", v, 32'h0);

        // R10: wrong sequences do not reload
        tick(20); rd(8'h10, a);
        wr(8'h28, K1); rd(8'h10, b);
        check("R10 lone second key", 32'(b > a), 32'd1);
        wr(8'h28, K0); wr(8'h28, 32'h1234_0000); wr(8'h28, K1); rd(8'h10, c);
        check("R10 broken pair", 32'(c > b), 32'd1);
        wr(8'h28, K0); wr(8'h28, K1); rd(8'h10, v);
        check("R10 pair still works", v, 32'h0);

        // R11: timeout P+1 clocks after reload, single pulse
        waited = 1;
        while (!rst_req && waited < 300) begin
            tick(1);
            waited++;
        end
        check("R11 timeout clock", 32'(waited), 32'd61);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            if (rst_req) pulses++;
            tick(1);
        end
        check("R11 R12 single pulse", 32'(pulses), 32'd1);
        rd(8'h28, v); check("R11 flag set", v, 32'h0000_C000);

        // R12: flag survives writes and service
        wr(8'h28, 32'h0000_0000); wr(8'h28, K0); wr(8'h28, K1);
        rd(8'h28, v); check("R12 flag sticky", v, 32'h0000_C000);

        // R1: reset clears everything again
        do_reset();
        rd(8'h28, v); check("R1 flag cleared by reset", v, 32'h0);
        rd(8'h18, v); check("R1 period cleared", v, 32'h0);
        wr(8'h18, 32'h5); rd(8'h18, v); check("R1 unlocked after reset", v, 32'h5);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule